// File: doc/BRIEF.md
# Addressed Peripheral Port

This block connects a simple processor bus to a single byte-wide external device. It claims a two-location address window. Each bus request carries one of four command kinds: control, test, read or write. A read fetches one character from the device into a data register, and the character waits there until the processor collects it. A write sends one bus byte to the device, with the top bit replaced by a generated parity bit. Every received character is checked against even or odd parity, whichever is selected. Parity failures and commands refused while busy are recorded as sticky error flags.

Completion can be polled through the status byte. When interrupts are enabled, completion also raises an interrupt line. The device side uses two valid/ready handshakes, one for each direction. Bus results appear on a registered read-data output one clock after the request.

Top module: `pio_port`

## Requirements
- R1: After reset, `rdata_o`, `irq_o`, `dev_ctl_o`, `dev_tx_valid_o` and `dev_rx_ready_o` are 0, and the status byte reads 0x00.
- R2: A request whose address differs from `BASE_ADDR` in any bit above bit 0 has no effect. The window is `BASE_ADDR` (data, bit 0 = 0) and `BASE_ADDR|1` (status, bit 0 = 1).
- R3: A read command (`cmd_i`=2) to the data location, when the module is idle and no character is waiting, sets BUSY and holds `dev_rx_ready_o` high. The byte presented with `dev_rx_valid_i` at the next such edge is stored, READY is set and BUSY is cleared.
- R4: A read command to the data location while READY is set drives the stored byte onto `rdata_o` one cycle later and clears READY.
- R5: A write command (`cmd_i`=3) while idle drives `dev_tx_valid_o` with `dev_tx_data_o` = {parity, `wdata_i[6:0]`}. Valid and data hold steady until `dev_tx_ready_i`, and BUSY is set throughout.
- R6: A received byte is in error when its count of ones is odd under even parity, or even under odd parity. An error sets the sticky PERR flag. Control bit 1 selects odd parity; the same bit sets the transmit parity bit so the total count of ones matches.
- R7: A read-data or write command issued while BUSY is ignored and sets the sticky OVR flag.
- R8: Status byte layout: bit0 READY, bit1 BUSY, bit2 PERR, bit3 OVR, bit4 interrupt enable, bit5 odd parity, bit6 interrupt pending, bit7 0. A read command to the status location returns this byte and clears PERR and OVR.
- R9: A test command (`cmd_i`=1) returns the status byte on `rdata_o` and changes no state.
- R10: A completed fetch sets interrupt pending. `irq_o` = pending AND control bit 0 (interrupt enable), so in polled mode `irq_o` stays 0.
- R11: Interrupt pending is cleared by collecting the data (R4) or by a control command with bit 3 set.
- R12: A control command (`cmd_i`=0) loads enable and parity from `wdata_i` bits 0 and 1. When bit 2 is set it also pulses `dev_ctl_o` high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request strobe, one cycle per command |
| addr_i | input | ADDR_W | Bus address |
| cmd_i | input | 2 | Command kind: 0 control, 1 test, 2 read, 3 write |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Registered read result |
| irq_o | output | 1 | Interrupt request |
| dev_rx_valid_i | input | 1 | Device offers a character |
| dev_rx_data_i | input | 8 | Character from device |
| dev_rx_ready_o | output | 1 | Module accepts a character |
| dev_tx_valid_o | output | 1 | Module offers a byte |
| dev_tx_data_o | output | 8 | Byte to device |
| dev_tx_ready_i | input | 1 | Device accepts the byte |
| dev_ctl_o | output | 1 | One-cycle device control pulse |

## Verification
Any request takes effect at the clock edge that samples it. Its `rdata_o` value, new status bits and device strobes can all be observed at the following falling edge. A received character changes READY, PERR, pending and `irq_o` at the edge where valid meets ready. The bench drives every input on a falling edge and samples one falling edge after the edge in question. It reads status back through test commands, which must not disturb it.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    CMD_CTRL  = 2'd0,
    CMD_TEST  = 2'd1,
    CMD_READ  = 2'd2,
    CMD_WRITE = 2'd3
  } pio_cmd_e;

  localparam int ST_READY = 0;
  localparam int ST_BUSY  = 1;
  localparam int ST_PERR  = 2;
  localparam int ST_OVR   = 3;
  localparam int ST_IEN   = 4;
  localparam int ST_PODD  = 5;
  localparam int ST_IPEND = 6;

  localparam int CT_IEN   = 0;
  localparam int CT_PODD  = 1;
  localparam int CT_PULSE = 2;
  localparam int CT_ACK   = 3;
endpackage

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        cmd_i,
  output logic              ctl_o,
  output logic              test_o,
  output logic              rd_data_o,
  output logic              rd_stat_o,
  output logic              wr_o
);
  localparam logic [ADDR_W-2:0] BASE_HI = BASE_ADDR[ADDR_W-1:1];

  logic     hit;
  pio_cmd_e cmd;

  assign hit = req_i && (addr_i[ADDR_W-1:1] == BASE_HI);
  assign cmd = pio_cmd_e'(cmd_i);

  always_comb begin
    ctl_o     = 1'b0;
    test_o    = 1'b0;
    rd_data_o = 1'b0;
    rd_stat_o = 1'b0;
    wr_o      = 1'b0;
    if (hit) begin
      unique case (cmd)
        CMD_CTRL:  ctl_o  = 1'b1;
        CMD_TEST:  test_o = 1'b1;
        CMD_READ:  if (addr_i[0]) rd_stat_o = 1'b1; else rd_data_o = 1'b1;
        CMD_WRITE: wr_o   = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/pio_rx.sv
module pio_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              collect_i,
  input  logic              podd_i,
  input  logic              dev_valid_i,
  input  logic [DATA_W-1:0] dev_data_i,
  output logic              dev_ready_o,
  output logic              busy_o,
  output logic              ready_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o,
  output logic              perr_o
);
  logic take;

  assign take        = busy_o && dev_valid_i;
  assign dev_ready_o = busy_o;
  assign done_o      = take;
  assign perr_o      = take && ((^dev_data_i) != podd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      ready_o <= 1'b0;
      data_o  <= '0;
    end else begin
      if (start_i)        busy_o <= 1'b1;
      else if (take)      busy_o <= 1'b0;
      if (take) begin
        ready_o <= 1'b1;
        data_o  <= dev_data_i;
      end else if (collect_i) begin
        ready_o <= 1'b0;
      end
    end
  end

  a_r3_ready_after_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(busy_o));
  a_r4_collect_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collect_i |=> !ready_o);
endmodule

// File: rtl/pio_tx.sv
module pio_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              podd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              dev_valid_o,
  output logic [DATA_W-1:0] dev_data_o,
  input  logic              dev_ready_i
);
  localparam int CODE_W = DATA_W - 1;

  logic unused_wmsb;
  logic par_bit;

  assign unused_wmsb = wdata_i[DATA_W-1];
  assign par_bit     = (^wdata_i[CODE_W-1:0]) ^ podd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_valid_o <= 1'b0;
      dev_data_o  <= '0;
    end else if (start_i) begin
      dev_valid_o <= 1'b1;
      dev_data_o  <= {par_bit, wdata_i[CODE_W-1:0]};
    end else if (dev_ready_i) begin
      dev_valid_o <= 1'b0;
    end
  end

  a_r5_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_valid_o && !dev_ready_i |=> dev_valid_o && $stable(dev_data_o));
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        cmd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o,
  input  logic              dev_rx_valid_i,
  input  logic [7:0]        dev_rx_data_i,
  output logic              dev_rx_ready_o,
  output logic              dev_tx_valid_o,
  output logic [7:0]        dev_tx_data_o,
  input  logic              dev_tx_ready_i,
  output logic              dev_ctl_o
);
  localparam int DATA_W = 8;

  logic ctl, test, rd_data, rd_stat, wr;
  logic busy, rx_busy, rx_ready, rx_done, rx_perr;
  logic rx_start, collect, tx_start;
  logic ien_q, podd_q, perr_q, ovr_q, ipend_q;
  logic [DATA_W-1:0] rx_data;
  logic [7:0] status;

  pio_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
    .req_i, .addr_i, .cmd_i,
    .ctl_o(ctl), .test_o(test), .rd_data_o(rd_data), .rd_stat_o(rd_stat), .wr_o(wr)
  );

  assign busy     = rx_busy || dev_tx_valid_o;
  assign rx_start = rd_data && !busy && !rx_ready;
  assign collect  = rd_data && !busy && rx_ready;
  assign tx_start = wr && !busy;

  pio_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni,
    .start_i(rx_start), .collect_i(collect), .podd_i(podd_q),
    .dev_valid_i(dev_rx_valid_i), .dev_data_i(dev_rx_data_i), .dev_ready_o(dev_rx_ready_o),
    .busy_o(rx_busy), .ready_o(rx_ready), .data_o(rx_data), .done_o(rx_done), .perr_o(rx_perr)
  );

  pio_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni,
    .start_i(tx_start), .podd_i(podd_q), .wdata_i(wdata_i),
    .dev_valid_o(dev_tx_valid_o), .dev_data_o(dev_tx_data_o), .dev_ready_i(dev_tx_ready_i)
  );

  always_comb begin
    status           = '0;
    status[ST_READY] = rx_ready;
    status[ST_BUSY]  = busy;
    status[ST_PERR]  = perr_q;
    status[ST_OVR]   = ovr_q;
    status[ST_IEN]   = ien_q;
    status[ST_PODD]  = podd_q;
    status[ST_IPEND] = ipend_q;
  end

  assign irq_o = ipend_q && ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q     <= 1'b0;
      podd_q    <= 1'b0;
      perr_q    <= 1'b0;
      ovr_q     <= 1'b0;
      ipend_q   <= 1'b0;
      dev_ctl_o <= 1'b0;
      rdata_o   <= '0;
    end else begin
      dev_ctl_o <= ctl && wdata_i[CT_PULSE];
      if (ctl) begin
        ien_q  <= wdata_i[CT_IEN];
        podd_q <= wdata_i[CT_PODD];
      end
      // new events win over a clear in the same cycle
      if (rx_perr)       perr_q <= 1'b1;
      else if (rd_stat)  perr_q <= 1'b0;
      if ((rd_data || wr) && busy) ovr_q <= 1'b1;
      else if (rd_stat)            ovr_q <= 1'b0;
      if (rx_done)                                  ipend_q <= 1'b1;
      else if (collect || (ctl && wdata_i[CT_ACK])) ipend_q <= 1'b0;
      if (test || rd_stat) rdata_o <= status;
      else if (collect)    rdata_o <= rx_data;
    end
  end

  a_r7_single_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_busy && dev_tx_valid_o));
  a_r10_irq_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rx_ready);
  a_r9_test_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test && !rx_done |=> $stable(perr_q) && $stable(ovr_q) && $stable(ipend_q));
endmodule

// File: tb/pio_port_tb.sv
`timescale 1ns/1ps
module pio_port_tb;
  localparam logic [7:0] A_DATA = 8'h40;
  localparam logic [7:0] A_STAT = 8'h41;
  localparam logic [1:0] C_CTRL = 2'd0, C_TEST = 2'd1, C_READ = 2'd2, C_WRITE = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [7:0] addr = '0;
  logic [1:0] cmd = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_ready;
  logic tx_valid;
  logic [7:0] tx_data;
  logic tx_ready = 1'b0;
  logic dev_ctl;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pio_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .cmd_i(cmd),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .dev_rx_valid_i(rx_valid), .dev_rx_data_i(rx_data), .dev_rx_ready_o(rx_ready),
    .dev_tx_valid_o(tx_valid), .dev_tx_data_o(tx_data), .dev_tx_ready_i(tx_ready),
    .dev_ctl_o(dev_ctl)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] tx_expect(input logic [7:0] d, input logic odd);
    int ones = 0;
    for (int i = 0; i < 7; i++) ones += d[i];
    return {logic'(ones % 2) ^ odd, d[6:0]};
  endfunction

  task automatic issue(input logic [7:0] a, input logic [1:0] c, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; addr = a; cmd = c; wdata = d;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic status_is(input string tag, input logic [7:0] exp);
    issue(A_STAT, C_TEST, 8'h00);
    chk(tag, rdata, exp);
  endtask

  task automatic dev_give(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 rx_ready", {7'd0, rx_ready}, 8'h00);
    chk("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
    chk("R1 dev_ctl", {7'd0, dev_ctl}, 8'h00);
    status_is("R1 status", 8'h00);
  endtask

  task automatic t_decode();
    issue(8'h50, C_WRITE, 8'h55);
    chk("R2 foreign write", {7'd0, tx_valid}, 8'h00);
    issue(8'h3F, C_READ, 8'h00);
    chk("R2 foreign read", {7'd0, rx_ready}, 8'h00);
    issue(8'h42, C_CTRL, 8'h07);
    chk("R2 foreign ctrl", {7'd0, dev_ctl}, 8'h00);
    status_is("R2 status untouched", 8'h00);
  endtask

  task automatic t_write();
    issue(A_DATA, C_CTRL, 8'h00);
    issue(A_DATA, C_WRITE, 8'h43);
    chk("R5 valid", {7'd0, tx_valid}, 8'h01);
    chk("R5 even data", tx_data, tx_expect(8'h43, 1'b0));
    status_is("R5 busy", 8'h02);
    issue(A_DATA, C_WRITE, 8'h11);
    chk("R7 write ignored", tx_data, tx_expect(8'h43, 1'b0));
    status_is("R7 overrun", 8'h0A);
    repeat (2) @(negedge clk);
    chk("R5 held", {tx_valid, tx_data[6:0]}, {1'b1, 7'h43});
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    chk("R5 released", {7'd0, tx_valid}, 8'h00);
    status_is("R9 test first", 8'h08);
    status_is("R9 test again", 8'h08);
    issue(A_STAT, C_READ, 8'h00);
    chk("R8 status read", rdata, 8'h08);
    status_is("R8 flags cleared", 8'h00);
    issue(A_DATA, C_CTRL, 8'h02);
    issue(A_DATA, C_WRITE, 8'h43);
    chk("R6 odd tx parity", tx_data, tx_expect(8'h43, 1'b1));
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    status_is("R12 odd mode", 8'h20);
  endtask

  task automatic t_read();
    issue(A_DATA, C_CTRL, 8'h00);
    issue(A_DATA, C_READ, 8'h00);
    chk("R3 rx_ready", {7'd0, rx_ready}, 8'h01);
    status_is("R3 busy", 8'h02);
    issue(A_DATA, C_READ, 8'h00);
    status_is("R7 read while busy", 8'h0A);
    dev_give(8'h41);
    chk("R3 rx_ready drop", {7'd0, rx_ready}, 8'h00);
    chk("R10 polled irq", {7'd0, irq}, 8'h00);
    status_is("R3 ready", 8'h49);
    issue(A_STAT, C_READ, 8'h00);
    chk("R8 read", rdata, 8'h49);
    issue(A_DATA, C_READ, 8'h00);
    chk("R4 collect", rdata, 8'h41);
    status_is("R4 ready cleared", 8'h00);
    issue(A_DATA, C_READ, 8'h00);
    dev_give(8'hC1);
    status_is("R6 even error", 8'h45);
    issue(A_DATA, C_READ, 8'h00);
    chk("R4 bad byte kept", rdata, 8'hC1);
    issue(A_STAT, C_READ, 8'h00);
    issue(A_DATA, C_CTRL, 8'h02);
    issue(A_DATA, C_READ, 8'h00);
    dev_give(8'hC1);
    status_is("R6 odd ok", 8'h61);
    issue(A_DATA, C_READ, 8'h00);
    issue(A_DATA, C_READ, 8'h00);
    dev_give(8'h41);
    status_is("R6 odd error", 8'h65);
    issue(A_DATA, C_READ, 8'h00);
    issue(A_STAT, C_READ, 8'h00);
    status_is("R8 clean", 8'h20);
  endtask

  task automatic t_irq();
    issue(A_DATA, C_CTRL, 8'h01);
    issue(A_DATA, C_READ, 8'h00);
    chk("R10 no irq yet", {7'd0, irq}, 8'h00);
    dev_give(8'h41);
    chk("R10 irq raised", {7'd0, irq}, 8'h01);
    status_is("R10 status", 8'h51);
    issue(A_DATA, C_READ, 8'h00);
    chk("R11 collect data", rdata, 8'h41);
    chk("R11 irq cleared by collect", {7'd0, irq}, 8'h00);
    issue(A_DATA, C_READ, 8'h00);
    dev_give(8'h41);
    chk("R10 irq again", {7'd0, irq}, 8'h01);
    issue(A_DATA, C_CTRL, 8'h09);
    chk("R11 irq cleared by ack", {7'd0, irq}, 8'h00);
    status_is("R11 data kept", 8'h11);
    issue(A_DATA, C_READ, 8'h00);
    issue(A_DATA, C_CTRL, 8'h00);
    issue(A_DATA, C_READ, 8'h00);
    dev_give(8'h41);
    chk("R10 polled no irq", {7'd0, irq}, 8'h00);
    status_is("R10 pending seen", 8'h41);
    issue(A_DATA, C_CTRL, 8'h01);
    chk("R10 enable shows pending", {7'd0, irq}, 8'h01);
    issue(A_DATA, C_READ, 8'h00);
    chk("R11 final collect", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_pulse();
    issue(A_DATA, C_CTRL, 8'h04);
    chk("R12 pulse high", {7'd0, dev_ctl}, 8'h01);
    @(negedge clk);
    chk("R12 pulse low", {7'd0, dev_ctl}, 8'h00);
    status_is("R12 ctrl fields", 8'h00);
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_write();
    t_read();
    t_irq();
    t_pulse();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule